// File: doc/BRIEF.md
# Pulse and Duty Cycle Capture Unit

This block times a digital input against the internal clock. In pulse mode it counts how many clock cycles the input stays in its active level and stores that count when the level ends. In duty mode it also keeps counting through the inactive phase. When the next active phase begins, it stores both the active-phase width and the full period in one update.

One input chooses which level is active, so a measurement can start on either a rising or a falling edge. Another input chooses between a single capture, after which the unit stops until it is re-enabled, and continuous capture, which measures every qualifying cycle. The input passes through a synchronizer before edge detection. Each completed capture sets a pending flag, and an enable gates that flag onto the interrupt line. A completion that arrives while the flag is still pending sets an overflow flag. A one-cycle clear strobe, issued when software reads the running count, clears both flags.

Top module: `pulse_capture`

## Requirements
- R1: After reset, both width results, the running count, the interrupt, the pending and overflow flags and busy are all 0.
- R2: With mode_duty=0, pulse_w takes the number of clock cycles the synchronized input spent in its active level, and cycle_w keeps its previous value.
- R3: With mode_duty=1, at the start of the following active phase pulse_w takes the active-phase width and cycle_w takes the count from one active start to the next, both in the same clock cycle.
- R4: act_low=0 makes high the active level, so a rising edge starts a measurement. act_low=1 makes low the active level, so a falling edge starts it.
- R5: With loop_en=0, busy drops after one completed capture, and later edges change no result until en has gone low and high again.
- R6: With loop_en=1, every qualifying cycle completes a capture and the unit stays busy. In duty mode the edge that closes one period also opens the next.
- R7: Each completed capture sets irq_raw, and irq equals irq_raw when irq_en=1 and stays 0 when irq_en=0.
- R8: A high rd_clr in a cycle with no completion clears irq_raw and irq_ovf on the next edge.
- R9: A completion while irq_raw is already set and rd_clr is low sets irq_ovf. irq_ovf is never set while irq_raw is clear.
- R10: If rd_clr and a completion occur in the same cycle, irq_raw ends set and irq_ovf ends clear.
- R11: Enabling while the input already sits in its active level does not start a measurement; the unit waits for the next start edge. Dropping en mid-measurement abandons it with no result and no flag.
- R12: pulse_w and cycle_w change only in the cycle right after a completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Unit enable; low stops and disarms |
| mode_duty | input | 1 | 0 pulse mode, 1 duty mode |
| act_low | input | 1 | 0 high level active, 1 low level active |
| loop_en | input | 1 | 0 single capture, 1 continuous capture |
| irq_en | input | 1 | Gates irq_raw onto irq |
| rd_clr | input | 1 | One-cycle strobe from a count read; clears the flags |
| sig_in | input | 1 | Asynchronous measured input |
| cur_count | output | CNT_W | Running cycle count |
| pulse_w | output | CNT_W | Active-phase width result |
| cycle_w | output | CNT_W | Full-period result (duty mode) |
| irq | output | 1 | Gated interrupt |
| irq_raw | output | 1 | Pending completion flag |
| irq_ovf | output | 1 | Completion seen while pending |
| busy | output | 1 | Armed or measuring |

## Verification
The clear strobe and a capture completion can land on the same clock edge. The bench provokes this in continuous pulse mode while the pending flag is already set. It drops the input and raises rd_clr exactly on the third edge after that change, which is where the synchronizer delay puts the terminating edge. That case passes only if the flag stays set, the overflow flag stays clear and the new width is stored. A second case repeats the completion with no clear, to show that the same timing does raise the overflow flag.

// File: rtl/pulse_capture.sv
module pulse_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode_duty,
  input  logic             act_low,
  input  logic             loop_en,
  input  logic             irq_en,
  input  logic             rd_clr,
  input  logic             sig_in,
  output logic [CNT_W-1:0] cur_count,
  output logic [CNT_W-1:0] pulse_w,
  output logic [CNT_W-1:0] cycle_w,
  output logic             irq,
  output logic             irq_raw,
  output logic             irq_ovf,
  output logic             busy
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [2:0] {S_OFF, S_ARM, S_HI, S_LO, S_END} st_t;

  st_t st, st_nxt;
  logic [SYNC_STAGES:0] sq;
  logic [CNT_W-1:0] cnt, cnt_nxt, hi_w, hi_nxt, cnt_inc;
  logic act_now, act_prev, rise, fall, done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sq <= '0;
    else        sq <= {sq[SYNC_STAGES-1:0], sig_in};

  assign act_now  = sq[SYNC_STAGES-1] ^ act_low;
  assign act_prev = sq[SYNC_STAGES] ^ act_low;
  assign rise     = act_now & ~act_prev;
  assign fall     = ~act_now & act_prev;
  assign cnt_inc  = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    hi_nxt  = hi_w;
    done    = 1'b0;
    if (!en) begin
      st_nxt = S_OFF;
    end else begin
      case (st)
        S_OFF: st_nxt = S_ARM;
        S_ARM:
          if (rise) begin
            st_nxt  = S_HI;
            cnt_nxt = CNT_ONE;
          end
        S_HI:
          if (fall) begin
            if (mode_duty) begin
              st_nxt  = S_LO;
              hi_nxt  = cnt;
              cnt_nxt = cnt_inc;
            end else begin
              done   = 1'b1;
              st_nxt = loop_en ? S_ARM : S_END;
            end
          end else begin
            cnt_nxt = cnt_inc;
          end
        S_LO:
          if (rise) begin
            done = 1'b1;
            if (loop_en) begin
              st_nxt  = S_HI;
              cnt_nxt = CNT_ONE;
            end else begin
              st_nxt = S_END;
            end
          end else begin
            cnt_nxt = cnt_inc;
          end
        default: st_nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_OFF;
      cnt     <= '0;
      hi_w    <= '0;
      pulse_w <= '0;
      cycle_w <= '0;
      irq_raw <= 1'b0;
      irq_ovf <= 1'b0;
    end else begin
      st   <= st_nxt;
      cnt  <= cnt_nxt;
      hi_w <= hi_nxt;
      if (done) begin
        if (mode_duty) begin
          pulse_w <= hi_w;
          cycle_w <= cnt;
        end else begin
          pulse_w <= cnt;
        end
        irq_raw <= 1'b1;
        irq_ovf <= ~rd_clr & (irq_ovf | irq_raw);
      end else if (rd_clr) begin
        irq_raw <= 1'b0;
        irq_ovf <= 1'b0;
      end
    end

  assign cur_count = cnt;
  assign irq       = irq_raw & irq_en;
  assign busy      = (st == S_ARM) || (st == S_HI) || (st == S_LO);

endmodule

// File: rtl/pulse_capture_chk.sv
module pulse_capture_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             mode_duty,
  input logic             loop_en,
  input logic             rd_clr,
  input logic             done,
  input logic [CNT_W-1:0] pulse_w,
  input logic [CNT_W-1:0] cycle_w,
  input logic             irq_raw,
  input logic             irq_ovf,
  input logic             busy
);

  p_ovf_needs_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> irq_raw);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !done) |=> (!irq_raw && !irq_ovf));

  p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && done) |=> (irq_raw && !irq_ovf));

  p_set_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> irq_raw);

  p_pair_update_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_w != $past(pulse_w) || cycle_w != $past(cycle_w)) |-> $past(done));

  p_pulse_keeps_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_duty) |=> $stable(cycle_w));

  p_single_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !loop_en) |=> !busy);

  p_disable_idles_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

endmodule

bind pulse_capture pulse_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode_duty(mode_duty), .loop_en(loop_en),
  .rd_clr(rd_clr), .done(done), .pulse_w(pulse_w), .cycle_w(cycle_w),
  .irq_raw(irq_raw), .irq_ovf(irq_ovf), .busy(busy)
);

// File: tb/pulse_capture_tb_top.sv
`timescale 1ns/1ps
module pulse_capture_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, mode_duty = 0, act_low = 0, loop_en = 0, irq_en = 0, rd_clr = 0, sig_in = 0;
  logic [W-1:0] cur_count, pulse_w, cycle_w;
  logic irq, irq_raw, irq_ovf, busy;
  int checks = 0, fails = 0;
  int exp_cycle = 0;

  always #2 clk = ~clk;

  pulse_capture #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_duty(mode_duty), .act_low(act_low),
    .loop_en(loop_en), .irq_en(irq_en), .rd_clr(rd_clr), .sig_in(sig_in),
    .cur_count(cur_count), .pulse_w(pulse_w), .cycle_w(cycle_w),
    .irq(irq), .irq_raw(irq_raw), .irq_ovf(irq_ovf), .busy(busy)
  );

  function automatic int exp_pulse(int n);
    return n;
  endfunction

  function automatic int exp_period(int n, int l);
    return n + l;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic hold(logic v, int n);
    sig_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flags();
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
  endtask

  task automatic setup(logic duty, logic al, logic lp);
    en = 1'b0;
    clear_flags();
    mode_duty = duty;
    act_low = al;
    loop_en = lp;
    hold(al, 3);
    en = 1'b1;
    hold(al, 3);
  endtask

  task automatic run_random(logic duty, logic al, int n, int l);
    setup(duty, al, 1'b0);
    hold(~al, n);
    hold(al, l);
    hold(~al, 1);
    hold(al, 6);
    check(duty ? "R3 pulse_w" : "R2 pulse_w", int'(pulse_w), exp_pulse(n));
    if (duty) exp_cycle = exp_period(n, l);
    check(duty ? "R3 cycle_w" : "R2 cycle_w kept", int'(cycle_w), exp_cycle);
    check("R4 R5 busy after single", int'(busy), 0);
    check("R7 irq_raw", int'(irq_raw), 1);
    check("R7 irq gate", int'(irq), int'(irq_en));
    check("R9 no overflow", int'(irq_ovf), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 pulse_w", int'(pulse_w), 0);
    check("R1 cycle_w", int'(cycle_w), 0);
    check("R1 cur_count", int'(cur_count), 0);
    check("R1 flags", int'({irq, irq_raw, irq_ovf, busy}), 0);

    for (int i = 0; i < 24; i++) begin
      int n, l;
      logic duty, al;
      n = int'($urandom % 20) + 1;
      l = int'($urandom % 20) + 1;
      duty = 1'($urandom);
      al = 1'($urandom);
      irq_en = 1'($urandom);
      if (i == 0) begin n = 1; l = 1; duty = 1'b1; end
      run_random(duty, al, n, l);
    end
    irq_en = 1'b1;

    // R11 armed while already active
    en = 1'b0; clear_flags(); mode_duty = 0; act_low = 0; loop_en = 0;
    hold(1'b1, 3);
    en = 1'b1;
    hold(1'b1, 4);
    hold(1'b0, 3);
    hold(1'b1, 5);
    hold(1'b0, 6);
    check("R11 armed while active", int'(pulse_w), 5);

    // R11 abort mid measurement
    setup(1'b0, 1'b0, 1'b0);
    hold(1'b1, 4);
    en = 1'b0;
    hold(1'b1, 2);
    hold(1'b0, 5);
    check("R11 abort no flag", int'(irq_raw), 0);
    check("R11 abort keeps result", int'(pulse_w), 5);
    check("R11 abort not busy", int'(busy), 0);

    // R5 single capture, then re-enable
    setup(1'b0, 1'b0, 1'b0);
    hold(1'b1, 4);
    hold(1'b0, 4);
    hold(1'b1, 7);
    hold(1'b0, 5);
    check("R5 single first only", int'(pulse_w), 4);
    check("R5 stopped", int'(busy), 0);
    en = 1'b0; hold(1'b0, 2);
    en = 1'b1; hold(1'b0, 3);
    hold(1'b1, 7);
    hold(1'b0, 5);
    check("R5 re-enabled capture", int'(pulse_w), 7);
    check("R9 overflow set", int'(irq_ovf), 1);

    // R6 loop duty, low active
    setup(1'b1, 1'b1, 1'b1);
    for (int k = 0; k < 4; k++) begin
      hold(1'b0, 3);
      hold(1'b1, 5);
    end
    check("R6 loop pulse_w", int'(pulse_w), 3);
    check("R6 loop cycle_w", int'(cycle_w), 8);
    check("R6 still busy", int'(busy), 1);
    check("R9 loop overflow", int'(irq_ovf), 1);
    clear_flags();
    @(negedge clk);
    check("R8 clear raw", int'(irq_raw), 0);
    check("R8 clear ovf", int'(irq_ovf), 0);

    // R10 clear colliding with completion, loop pulse mode
    setup(1'b0, 1'b0, 1'b1);
    hold(1'b1, 3);
    hold(1'b0, 5);
    check("R6 loop first", int'(pulse_w), 3);
    hold(1'b1, 6);
    sig_in = 1'b0;
    repeat (2) @(negedge clk);
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
    hold(1'b0, 4);
    check("R10 raw kept", int'(irq_raw), 1);
    check("R10 ovf clear", int'(irq_ovf), 0);
    check("R10 width stored", int'(pulse_w), 6);
    hold(1'b1, 2);
    hold(1'b0, 5);
    check("R6 loop again", int'(pulse_w), 2);
    check("R9 ovf after uncleared", int'(irq_ovf), 1);
    check("R2 cycle_w kept in pulse", int'(cycle_w), 8);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule